// File: doc/BRIEF.md
# Machine Trap and Status Register File

This block keeps the trap-handling and status registers of a small 32-bit hart at machine and supervisor level. Every write passes through legalisation: bits that are not implemented drop out, and field values that are not supported leave the old contents in place. A read always returns a legal value. The block has one write port (address, data, enable) and one read port (address, data). Each port has an illegal flag that is combinational in the same cycle. The block also exports the live status word, the interrupt-enable word and both delegation words, so that trap and interrupt logic elsewhere can use them.

The supervisor status, enable and pending registers hold no storage of their own. Each one is a masked window onto the machine register behind it. A write through a window merges into the machine word and then goes through the same legalisation as a direct write. Two static inputs state whether supervisor mode and user mode are present. They decide which previous-privilege encodings a status write may store. Register addresses follow the standard 12-bit control-register numbering of the architecture, because instruction decode elsewhere depends on those numbers.

Top module: `msr_csr_file`

## Requirements
- R1: After reset every register reads zero. This includes the status word, so the previous-privilege field (bits 12:11) reads user mode (0).
- R2: A write to the machine status word (0x300) changes only the bits in mask 0x000E79AA, and bit 31 is recomputed. Every other bit keeps its value. With no write, the status word holds.
- R3: The previous-privilege field is left unchanged when the written value is 2, when it is 1 with supervisor mode absent, or when it is 0 with user mode absent. Every other value is stored.
- R4: After masking, a nonzero floating-point state field (bits 14:13) is stored as 3. Bit 31 always equals (bits 14:13 == 3) OR (bits 16:15 == 3).
- R5: Machine interrupt-enable (0x304) keeps only the bits in 0x2AA. Interrupt delegation (0x303) keeps only the bits in 0x222. Of machine interrupt-pending (0x344), only the bits in 0x022 are writable.
- R6: Exception delegation (0x302) keeps only bits 0 to 13 and bit 15 (mask 0xBFFF).
- R7: A write to a trap vector (0x305 machine, 0x105 supervisor) is stored only when data bits 1:0 are 0. Any other value leaves the register unchanged.
- R8: The supervisor enable (0x104) and pending (0x144) windows read as the machine register ANDed with interrupt delegation. A write through either window changes only the delegated bits, and then goes through the masking in R5.
- R9: The supervisor status window (0x100) reads the status word ANDed with 0x800DE133. A write through it merges under that mask into the status word and then goes through R2 to R4.
- R10: Vendor (0xF11), architecture (0xF12) and implementation (0xF13) IDs read zero. Hart ID (0xF14) reads the `hart_id` input. A write to any of these four is illegal.
- R11: A read or write to an address this block does not implement raises the matching illegal flag in the same cycle. Read data is then zero and no state changes.
- R12: The scratch, exception-PC, cause and fault-value registers hold full 32-bit values. The machine set is at 0x340..0x343 and the supervisor set at 0x140..0x143.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| has_smode | input | 1 | Static: supervisor mode implemented |
| has_umode | input | 1 | Static: user mode implemented |
| hart_id | input | 32 | Value returned by the hart-ID register |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 32 | Write data before legalisation |
| wr_illegal | output | 1 | Write strobe aimed at an unimplemented or read-only address |
| rd_addr | input | 12 | Read address |
| rd_data | output | 32 | Read data, zero when illegal |
| rd_illegal | output | 1 | Read address not implemented |
| status_o | output | 32 | Current machine status word |
| irq_enable_o | output | 32 | Current machine interrupt-enable word |
| irq_deleg_o | output | 32 | Current interrupt-delegation word |
| exc_deleg_o | output | 32 | Current exception-delegation word |

## Verification
The bench builds the block with its default parameters: 32-bit data, 12-bit addresses and the supervisor windows enabled. With the windows enabled, merging through an alias, with the delegation mask changing between writes, can be reached from the ports. The bench also resets the block under different settings of the two mode inputs. This exercises every branch of the previous-privilege drop rule, and then the rejected writes to trap vectors, read-only IDs and unmapped addresses.

// File: rtl/msr_pkg.sv
package msr_pkg;

   // Architectural register numbers; decode elsewhere relies on them.
   localparam logic [11:0] A_SSTATUS  = 12'h100;
   localparam logic [11:0] A_SIE      = 12'h104;
   localparam logic [11:0] A_STVEC    = 12'h105;
   localparam logic [11:0] A_SSCRATCH = 12'h140;
   localparam logic [11:0] A_SIP      = 12'h144;
   localparam logic [11:0] A_MSTATUS  = 12'h300;
   localparam logic [11:0] A_MEDELEG  = 12'h302;
   localparam logic [11:0] A_MIDELEG  = 12'h303;
   localparam logic [11:0] A_MIE      = 12'h304;
   localparam logic [11:0] A_MTVEC    = 12'h305;
   localparam logic [11:0] A_MSCRATCH = 12'h340;
   localparam logic [11:0] A_MIP      = 12'h344;
   localparam logic [11:0] A_VENDOR   = 12'hF11;
   localparam logic [11:0] A_ARCH     = 12'hF12;
   localparam logic [11:0] A_IMPL     = 12'hF13;
   localparam logic [11:0] A_HART     = 12'hF14;

   // Status field positions
   localparam int MPP_LO = 11;
   localparam int FS_LO  = 13;
   localparam int XS_LO  = 15;
   localparam int SD_BIT = 31;

   // Legalisation masks
   localparam logic [31:0] STAT_WMASK = 32'h000E_79AA;
   localparam logic [31:0] SSTAT_VIEW = 32'h800D_E133;
   localparam logic [31:0] IE_MASK    = 32'h0000_02AA;
   localparam logic [31:0] IDLG_MASK  = 32'h0000_0222;
   localparam logic [31:0] IP_WMASK   = 32'h0000_0022;
   localparam logic [31:0] EDLG_MASK  = 32'h0000_BFFF;

   typedef enum logic [1:0] {
      PRV_U    = 2'd0,
      PRV_S    = 2'd1,
      PRV_RSVD = 2'd2,
      PRV_M    = 2'd3
   } priv_e;

endpackage

// File: rtl/msr_status_unit.sv
module msr_status_unit
   import msr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int ADDR_W     = 12,
   parameter bit SUPV_VIEWS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              has_smode,
   input  logic              has_umode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   output logic              rd_hit,
   output logic              wr_hit,
   output logic [XLEN-1:0]   status_o
);

   localparam logic [XLEN-1:0] KEEP_BITS = ~(STAT_WMASK | (32'h1 << SD_BIT));

   logic [XLEN-1:0] stat_q, merged, next_stat, wmask;
   logic            m_hit_w, s_hit_w, m_hit_r, s_hit_r, mpp_ok;
   priv_e           mpp_req;

   assign m_hit_w = (wr_addr == ADDR_W'(A_MSTATUS));
   assign m_hit_r = (rd_addr == ADDR_W'(A_MSTATUS));

   generate
      if (SUPV_VIEWS) begin : g_sview
         assign s_hit_w = (wr_addr == ADDR_W'(A_SSTATUS));
         assign s_hit_r = (rd_addr == ADDR_W'(A_SSTATUS));
      end else begin : g_no_sview
         assign s_hit_w = 1'b0;
         assign s_hit_r = 1'b0;
      end
   endgenerate

   assign wr_hit = m_hit_w | s_hit_w;
   assign rd_hit = m_hit_r | s_hit_r;

   always_comb begin
      merged  = s_hit_w ? ((stat_q & ~SSTAT_VIEW) | (wr_data & SSTAT_VIEW)) : wr_data;
      mpp_req = priv_e'(merged[MPP_LO +: 2]);
      mpp_ok  = !((mpp_req == PRV_RSVD) ||
                  (mpp_req == PRV_S && !has_smode) ||
                  (mpp_req == PRV_U && !has_umode));
      wmask = STAT_WMASK;
      if (!mpp_ok) wmask[MPP_LO +: 2] = 2'b00;
      next_stat = (stat_q & ~wmask) | (merged & wmask);
      if (next_stat[FS_LO +: 2] != 2'b00) next_stat[FS_LO +: 2] = 2'b11;
      next_stat[SD_BIT] = (next_stat[FS_LO +: 2] == 2'b11) ||
                          (next_stat[XS_LO +: 2] == 2'b11);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                stat_q <= '0;
      else if (wr_en && wr_hit)  stat_q <= next_stat;
   end

   always_comb begin
      if (m_hit_r)      rd_data = stat_q;
      else if (s_hit_r) rd_data = stat_q & SSTAT_VIEW;
      else              rd_data = '0;
   end

   assign status_o = stat_q;

   // Field invariants of the stored word
   assert_fs_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[FS_LO +: 2] == 2'b00) || (stat_q[FS_LO +: 2] == 2'b11));
   assert_sd_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[SD_BIT] == ((stat_q[FS_LO +: 2] == 2'b11) || (stat_q[XS_LO +: 2] == 2'b11)));
   assert_mpp_not_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[MPP_LO +: 2] != 2'b10);
   assert_keep_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hit) |=> ((stat_q & KEEP_BITS) == $past(stat_q & KEEP_BITS)));
   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_hit) |=> $stable(stat_q));

endmodule

// File: rtl/msr_irq_unit.sv
module msr_irq_unit
   import msr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int ADDR_W     = 12,
   parameter bit SUPV_VIEWS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   output logic              rd_hit,
   output logic              wr_hit,
   output logic [XLEN-1:0]   irq_enable_o,
   output logic [XLEN-1:0]   irq_deleg_o,
   output logic [XLEN-1:0]   exc_deleg_o
);

   logic [XLEN-1:0] mie_q, mip_q, ideleg_q, edeleg_q;
   logic [XLEN-1:0] mie_d, mip_d, ideleg_d, edeleg_d, alias_v;
   logic            w_mie, w_mip, w_ideleg, w_edeleg, w_sie, w_sip;
   logic            r_sie, r_sip;

   assign w_mie    = (wr_addr == ADDR_W'(A_MIE));
   assign w_mip    = (wr_addr == ADDR_W'(A_MIP));
   assign w_ideleg = (wr_addr == ADDR_W'(A_MIDELEG));
   assign w_edeleg = (wr_addr == ADDR_W'(A_MEDELEG));

   generate
      if (SUPV_VIEWS) begin : g_sview
         assign w_sie = (wr_addr == ADDR_W'(A_SIE));
         assign w_sip = (wr_addr == ADDR_W'(A_SIP));
         assign r_sie = (rd_addr == ADDR_W'(A_SIE));
         assign r_sip = (rd_addr == ADDR_W'(A_SIP));
      end else begin : g_no_sview
         assign w_sie = 1'b0;
         assign w_sip = 1'b0;
         assign r_sie = 1'b0;
         assign r_sip = 1'b0;
      end
   endgenerate

   assign wr_hit = w_mie | w_mip | w_ideleg | w_edeleg | w_sie | w_sip;

   always_comb begin
      mie_d    = mie_q;
      mip_d    = mip_q;
      ideleg_d = ideleg_q;
      edeleg_d = edeleg_q;
      alias_v  = '0;
      if (w_mie) mie_d = (mie_q & ~IE_MASK) | (wr_data & IE_MASK);
      if (w_sie) begin
         alias_v = (mie_q & ~ideleg_q) | (wr_data & ideleg_q);
         mie_d   = (mie_q & ~IE_MASK) | (alias_v & IE_MASK);
      end
      if (w_mip) mip_d = (mip_q & ~IP_WMASK) | (wr_data & IP_WMASK);
      if (w_sip) begin
         alias_v = (mip_q & ~ideleg_q) | (wr_data & ideleg_q);
         mip_d   = (mip_q & ~IP_WMASK) | (alias_v & IP_WMASK);
      end
      if (w_ideleg) ideleg_d = (ideleg_q & ~IDLG_MASK) | (wr_data & IDLG_MASK);
      if (w_edeleg) edeleg_d = (edeleg_q & ~EDLG_MASK) | (wr_data & EDLG_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mie_q    <= '0;
         mip_q    <= '0;
         ideleg_q <= '0;
         edeleg_q <= '0;
      end else if (wr_en && wr_hit) begin
         mie_q    <= mie_d;
         mip_q    <= mip_d;
         ideleg_q <= ideleg_d;
         edeleg_q <= edeleg_d;
      end
   end

   always_comb begin
      rd_hit  = 1'b1;
      rd_data = '0;
      if      (rd_addr == ADDR_W'(A_MIE))     rd_data = mie_q;
      else if (rd_addr == ADDR_W'(A_MIP))     rd_data = mip_q;
      else if (rd_addr == ADDR_W'(A_MIDELEG)) rd_data = ideleg_q;
      else if (rd_addr == ADDR_W'(A_MEDELEG)) rd_data = edeleg_q;
      else if (r_sie)                         rd_data = mie_q & ideleg_q;
      else if (r_sip)                         rd_data = mip_q & ideleg_q;
      else                                    rd_hit  = 1'b0;
   end

   assign irq_enable_o = mie_q;
   assign irq_deleg_o  = ideleg_q;
   assign exc_deleg_o  = edeleg_q;

   assert_ie_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mie_q & ~IE_MASK) == '0);
   assert_ideleg_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ideleg_q & ~IDLG_MASK) == '0);
   assert_ip_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mip_q & ~IP_WMASK) == '0);
   assert_edeleg_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edeleg_q & ~EDLG_MASK) == '0);
   assert_sie_only_deleg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && w_sie) |=> ((mie_q & ~ideleg_q) == $past(mie_q & ~ideleg_q)));
   assert_sip_only_deleg_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && w_sip) |=> ((mip_q & ~ideleg_q) == $past(mip_q & ~ideleg_q)));

endmodule

// File: rtl/msr_trap_bank.sv
module msr_trap_bank #(
   parameter int          XLEN      = 32,
   parameter int          ADDR_W    = 12,
   parameter int          NUM_PLAIN = 4,
   parameter logic [11:0] TVEC_ADDR = 12'h305,
   parameter logic [11:0] BASE_ADDR = 12'h340
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   output logic              rd_hit,
   output logic              wr_hit
);

   logic [XLEN-1:0]      tvec_q;
   logic [XLEN-1:0]      plain_q [NUM_PLAIN];
   logic [NUM_PLAIN-1:0] plain_wsel;
   logic                 tvec_wsel, tvec_mode_ok;

   assign tvec_wsel    = (wr_addr == ADDR_W'(TVEC_ADDR));
   assign tvec_mode_ok = (wr_data[1:0] == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n)                                   tvec_q <= '0;
      else if (wr_en && tvec_wsel && tvec_mode_ok)  tvec_q <= {wr_data[XLEN-1:2], 2'b00};
   end

   generate
      for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
         assign plain_wsel[g] = (wr_addr == ADDR_W'(BASE_ADDR + g));
         always_ff @(posedge clk) begin
            if (!rst_n)                         plain_q[g] <= '0;
            else if (wr_en && plain_wsel[g])    plain_q[g] <= wr_data;
         end
      end
   endgenerate

   assign wr_hit = tvec_wsel | (|plain_wsel);

   always_comb begin
      rd_hit  = 1'b0;
      rd_data = '0;
      if (rd_addr == ADDR_W'(TVEC_ADDR)) begin
         rd_hit  = 1'b1;
         rd_data = tvec_q;
      end
      for (int i = 0; i < NUM_PLAIN; i++) begin
         if (rd_addr == ADDR_W'(BASE_ADDR + i)) begin
            rd_hit  = 1'b1;
            rd_data = plain_q[i];
         end
      end
   end

   assert_tvec_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tvec_q[1:0] == 2'b00);
   assert_tvec_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tvec_wsel && !tvec_mode_ok) |=> $stable(tvec_q));

endmodule

// File: rtl/msr_csr_file.sv
module msr_csr_file
   import msr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int ADDR_W     = 12,
   parameter bit SUPV_VIEWS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              has_smode,
   input  logic              has_umode,
   input  logic [XLEN-1:0]   hart_id,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [XLEN-1:0]   wr_data,
   output logic              wr_illegal,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   output logic              rd_illegal,
   output logic [XLEN-1:0]   status_o,
   output logic [XLEN-1:0]   irq_enable_o,
   output logic [XLEN-1:0]   irq_deleg_o,
   output logic [XLEN-1:0]   exc_deleg_o
);

   localparam int NUM_LVL   = 2;   // 0: supervisor bank, 1: machine bank
   localparam int NUM_UNITS = NUM_LVL + 3;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("msr_csr_file: XLEN must be 32");
      end
      if (ADDR_W != 12) begin : g_bad_addr
         $error("msr_csr_file: ADDR_W must be 12");
      end
   endgenerate

   logic [XLEN-1:0]      u_rd   [NUM_UNITS];
   logic [NUM_UNITS-1:0] u_rhit, u_whit;

   msr_status_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W), .SUPV_VIEWS(SUPV_VIEWS)) u_status (
      .clk(clk), .rst_n(rst_n), .has_smode(has_smode), .has_umode(has_umode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(u_rd[0]), .rd_hit(u_rhit[0]), .wr_hit(u_whit[0]), .status_o(status_o)
   );

   msr_irq_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W), .SUPV_VIEWS(SUPV_VIEWS)) u_irq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(u_rd[1]), .rd_hit(u_rhit[1]), .wr_hit(u_whit[1]),
      .irq_enable_o(irq_enable_o), .irq_deleg_o(irq_deleg_o), .exc_deleg_o(exc_deleg_o)
   );

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         if (l == 0 && !SUPV_VIEWS) begin : g_off
            assign u_rd[2+l]   = '0;
            assign u_rhit[2+l] = 1'b0;
            assign u_whit[2+l] = 1'b0;
         end else begin : g_on
            msr_trap_bank #(
               .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_PLAIN(4),
               .TVEC_ADDR(l == 0 ? A_STVEC : A_MTVEC),
               .BASE_ADDR(l == 0 ? A_SSCRATCH : A_MSCRATCH)
            ) u_bank (
               .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
               .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(u_rd[2+l]),
               .rd_hit(u_rhit[2+l]), .wr_hit(u_whit[2+l])
            );
         end
      end
   endgenerate

   // Identity registers: read-only, never a write target
   always_comb begin
      u_rhit[NUM_UNITS-1] = (rd_addr == ADDR_W'(A_VENDOR)) || (rd_addr == ADDR_W'(A_ARCH)) ||
                            (rd_addr == ADDR_W'(A_IMPL))   || (rd_addr == ADDR_W'(A_HART));
      u_rd[NUM_UNITS-1]   = (rd_addr == ADDR_W'(A_HART)) ? hart_id : '0;
      u_whit[NUM_UNITS-1] = 1'b0;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_UNITS; i++) rd_data = rd_data | u_rd[i];
   end

   assign rd_illegal = ~(|u_rhit);
   assign wr_illegal = wr_en & ~(|u_whit);

   assert_decode_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(u_rhit) && $onehot0(u_whit));
   assert_illegal_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_illegal |-> (rd_data == '0));
   assert_illegal_wr_nochange_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_illegal |=> ($stable(status_o) && $stable(irq_enable_o) &&
                      $stable(irq_deleg_o) && $stable(exc_deleg_o)));
   assert_id_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(A_VENDOR) || rd_addr == ADDR_W'(A_IMPL)) |-> (rd_data == '0));

endmodule

// File: tb/sim_msr_csr_file.sv
module sim_msr_csr_file;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        has_smode = 1'b1, has_umode = 1'b1;
   logic [31:0] hart_id = 32'h0000_0005;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_illegal, rd_illegal;
   logic [31:0] rd_data, status_o, irq_enable_o, irq_deleg_o, exc_deleg_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   msr_csr_file u0 (
      .clk(clk), .rst_n(rst_n), .has_smode(has_smode), .has_umode(has_umode),
      .hart_id(hart_id), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_illegal(wr_illegal), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_illegal(rd_illegal), .status_o(status_o), .irq_enable_o(irq_enable_o),
      .irq_deleg_o(irq_deleg_o), .exc_deleg_o(exc_deleg_o)
   );

   // {req[4], we, waddr[12], wdata[32], raddr[12], rdata[32], rd_ill, wr_ill}
   localparam int NV = 31;
   localparam logic [94:0] VEC [NV] = '{
      {4'd2,  1'b1, 12'h300, 32'hFFFF_FFFF, 12'h300, 32'h800E_79AA, 1'b0, 1'b0}, // R2
      {4'd4,  1'b1, 12'h300, 32'h0000_2000, 12'h300, 32'h8000_6000, 1'b0, 1'b0}, // R4
      {4'd3,  1'b1, 12'h300, 32'h0000_1800, 12'h300, 32'h0000_1800, 1'b0, 1'b0}, // R3
      {4'd3,  1'b1, 12'h300, 32'h0000_1000, 12'h300, 32'h0000_1800, 1'b0, 1'b0}, // R3
      {4'd3,  1'b1, 12'h300, 32'h0000_0000, 12'h300, 32'h0000_0000, 1'b0, 1'b0}, // R3
      {4'd9,  1'b1, 12'h100, 32'hFFFF_FFFF, 12'h100, 32'h800C_6122, 1'b0, 1'b0}, // R9
      {4'd9,  1'b0, 12'h000, 32'h0000_0000, 12'h300, 32'h800C_6122, 1'b0, 1'b0}, // R9
      {4'd2,  1'b1, 12'h300, 32'h0000_0008, 12'h300, 32'h0000_0008, 1'b0, 1'b0}, // R2
      {4'd9,  1'b1, 12'h100, 32'h0000_0000, 12'h300, 32'h0000_0008, 1'b0, 1'b0}, // R9
      {4'd5,  1'b1, 12'h304, 32'hFFFF_FFFF, 12'h304, 32'h0000_02AA, 1'b0, 1'b0}, // R5
      {4'd5,  1'b1, 12'h303, 32'hFFFF_FFFF, 12'h303, 32'h0000_0222, 1'b0, 1'b0}, // R5
      {4'd8,  1'b0, 12'h000, 32'h0000_0000, 12'h104, 32'h0000_0222, 1'b0, 1'b0}, // R8
      {4'd8,  1'b1, 12'h104, 32'h0000_0000, 12'h304, 32'h0000_0088, 1'b0, 1'b0}, // R8
      {4'd5,  1'b1, 12'h303, 32'h0000_0020, 12'h303, 32'h0000_0020, 1'b0, 1'b0}, // R5
      {4'd8,  1'b1, 12'h104, 32'hFFFF_FFFF, 12'h304, 32'h0000_00A8, 1'b0, 1'b0}, // R8
      {4'd5,  1'b1, 12'h344, 32'hFFFF_FFFF, 12'h344, 32'h0000_0022, 1'b0, 1'b0}, // R5
      {4'd8,  1'b1, 12'h144, 32'h0000_0000, 12'h344, 32'h0000_0002, 1'b0, 1'b0}, // R8
      {4'd8,  1'b0, 12'h000, 32'h0000_0000, 12'h144, 32'h0000_0000, 1'b0, 1'b0}, // R8
      {4'd6,  1'b1, 12'h302, 32'hFFFF_FFFF, 12'h302, 32'h0000_BFFF, 1'b0, 1'b0}, // R6
      {4'd7,  1'b1, 12'h305, 32'h8000_1000, 12'h305, 32'h8000_1000, 1'b0, 1'b0}, // R7
      {4'd7,  1'b1, 12'h305, 32'h1234_5601, 12'h305, 32'h8000_1000, 1'b0, 1'b0}, // R7
      {4'd7,  1'b1, 12'h305, 32'h1234_5602, 12'h305, 32'h8000_1000, 1'b0, 1'b0}, // R7
      {4'd7,  1'b1, 12'h105, 32'h0000_0400, 12'h105, 32'h0000_0400, 1'b0, 1'b0}, // R7
      {4'd12, 1'b1, 12'h340, 32'hDEAD_BEEF, 12'h340, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R12
      {4'd12, 1'b1, 12'h141, 32'h1357_2468, 12'h141, 32'h1357_2468, 1'b0, 1'b0}, // R12
      {4'd12, 1'b1, 12'h342, 32'h8000_000B, 12'h342, 32'h8000_000B, 1'b0, 1'b0}, // R12
      {4'd12, 1'b1, 12'h143, 32'hCAFE_F00D, 12'h143, 32'hCAFE_F00D, 1'b0, 1'b0}, // R12
      {4'd10, 1'b1, 12'hF11, 32'hFFFF_FFFF, 12'hF11, 32'h0000_0000, 1'b0, 1'b1}, // R10
      {4'd10, 1'b0, 12'h000, 32'h0000_0000, 12'hF14, 32'h0000_0005, 1'b0, 1'b0}, // R10
      {4'd11, 1'b1, 12'h7C0, 32'hFFFF_FFFF, 12'h340, 32'hDEAD_BEEF, 1'b0, 1'b1}, // R11
      {4'd11, 1'b0, 12'h000, 32'h0000_0000, 12'h7C0, 32'h0000_0000, 1'b1, 1'b0}  // R11
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic s, input logic u);
      @(negedge clk);
      rst_n = 1'b0; has_smode = s; has_umode = u; wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      do_reset(1'b1, 1'b1);
      // R1: reset state
      read_chk("R1 status", 12'h300, 32'h0);
      check("R1 rd_illegal", {31'b0, rd_illegal}, 32'h0);
      check("R1 status_o", status_o, 32'h0);
      read_chk("R1 mie", 12'h304, 32'h0);
      read_chk("R1 mscratch", 12'h340, 32'h0);
      read_chk("R1 mtvec", 12'h305, 32'h0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [94:0] v;
         string t;
         v = VEC[i];
         t = $sformatf("R%0d vec%0d", v[94:91], i);
         @(negedge clk);
         wr_en = v[90]; wr_addr = v[89:78]; wr_data = v[77:46];
         #1;
         check({t, " wr_illegal"}, {31'b0, wr_illegal}, {31'b0, v[0]});
         @(negedge clk);
         wr_en = 1'b0;
         rd_addr = v[45:34];
         #1;
         check({t, " rd_data"}, rd_data, v[33:2]);
         check({t, " rd_illegal"}, {31'b0, rd_illegal}, {31'b0, v[1]});
      end

      // Exported words after the table (R5, R6, R2)
      check("R5 irq_enable_o", irq_enable_o, 32'h0000_00A8);
      check("R5 irq_deleg_o", irq_deleg_o, 32'h0000_0020);
      check("R6 exc_deleg_o", exc_deleg_o, 32'h0000_BFFF);
      check("R2 status_o", status_o, 32'h0000_0008);

      // R4: FS value 2 is stored as 3
      write_reg(12'h300, 32'h0000_4000);
      read_chk("R4 fs2", 12'h300, 32'h8000_6000);

      // R3: supervisor mode absent
      do_reset(1'b0, 1'b1);
      write_reg(12'h300, 32'h0000_0800);
      read_chk("R3 nos mpp1", 12'h300, 32'h0);
      write_reg(12'h300, 32'h0000_1800);
      read_chk("R3 nos mpp3", 12'h300, 32'h0000_1800);
      write_reg(12'h300, 32'h0000_0800);
      read_chk("R3 nos keep", 12'h300, 32'h0000_1800);

      // R3: user mode absent
      do_reset(1'b1, 1'b0);
      write_reg(12'h300, 32'h0000_1800);
      read_chk("R3 nou mpp3", 12'h300, 32'h0000_1800);
      write_reg(12'h300, 32'h0000_0000);
      read_chk("R3 nou mpp0", 12'h300, 32'h0000_1800);
      write_reg(12'h300, 32'h0000_0800);
      read_chk("R3 nou mpp1", 12'h300, 32'h0000_0800);

      // R11: illegal write leaves exported words alone
      write_reg(12'h3A0, 32'hFFFF_FFFF);
      check("R11 status_o", status_o, 32'h0000_0800);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule